// File: doc/BRIEF.md
# Toggle-Synchronized Dual-Clock FIFO

This block moves a stream of data words from one clock domain into another, unrelated one. The writer offers words over a valid/ready handshake on its own clock. The reader takes them over a second valid/ready handshake on the read clock. Only one occupancy count exists, and it lives entirely on the read side. Each accepted write flips a single toggle bit. A two-stage synchronizer carries that bit into the read domain, and every edge seen there adds one to the count. The read side derives its valid and half-full indications from that count. It also raises an almost-full level, which a second two-stage synchronizer carries back to the writer, where it becomes the write-side ready.

Back-pressure rules: a write transfers on a write-clock edge where `wr_valid` and `wr_ready` are both high. The writer must hold `wr_valid` low while `wr_ready` is low. A write offered while `wr_ready` is low is not stored, and it sets the sticky `wr_overflow`. A read transfers on a read-clock edge where `rd_valid` and `rd_ready` are both high. `rd_ready` may be high at any time, and it has no effect while `rd_valid` is low.

The read clock must be fast enough that no two write toggles fall inside one synchronizer settling window. In practice this means the read clock is well above the write clock, about twice its rate or more. The almost-full margin must cover the round trip from a write, through the count, and back to `wr_ready`.

Top module: `tcf_fifo`

## Requirements
- R1: While `wr_rst` and `rd_rst` are both held for several cycles of each clock, and after they are released, `rd_valid` is 0, `rd_half` is 0, `wr_afull` is 0, `wr_ready` is 1 and `wr_overflow` is 0.
- R2: Words leave on `rd_data` in exactly the order and with exactly the values in which they were accepted on `wr_data`.
- R3: Each accepted write flips the write-side toggle once. Each toggle edge is counted exactly once in the read domain, so after one write into an empty FIFO, `rd_valid` becomes 1 within a few read-clock cycles.
- R4: `rd_valid` is 1 exactly when the count is non-zero. `rd_ready` while `rd_valid` is 0 changes neither the count nor the read position.
- R5: In a read-clock cycle where a counted write event and a read transfer coincide, the count holds. A write event alone adds one and a read alone subtracts one. The count never exceeds DEPTH.
- R6: `rd_half` is 1 exactly when the count is at least DEPTH/2 (8 with the defaults).
- R7: The read side flags almost-full when the count reaches DEPTH-MARGIN (12 with the defaults). The flag reaches `wr_afull` through two write-clock flops, and `wr_ready` is its inverse. A writer that obeys `wr_ready` gets between DEPTH-MARGIN and DEPTH words accepted before it is stopped. `wr_afull` clears again once the FIFO has drained.
- R8: A write offered while `wr_ready` is 0 is dropped and sets `wr_overflow`. The flag stays at 1 until `wr_rst` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous reset, write domain, active high |
| wr_valid | input | 1 | Writer offers a word |
| wr_data | input | DW | Word offered by the writer |
| wr_ready | output | 1 | Writer may offer a word (not almost-full) |
| wr_afull | output | 1 | Synchronized almost-full level |
| wr_overflow | output | 1 | Sticky: a word was offered while not ready |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Synchronous reset, read domain, active high |
| rd_valid | output | 1 | A word is available |
| rd_ready | input | 1 | Reader takes the word this cycle |
| rd_data | output | DW | Oldest stored word |
| rd_half | output | 1 | Count is at least DEPTH/2 |

## Verification
Single isolated writes into an empty FIFO separate a correctly counted toggle edge from a missed or doubled one. Both would show up as a missing word or an extra word in the ordered scoreboard. A fill with the reader stalled probes the half-full threshold at one below and at exactly DEPTH/2. It then shows that the almost-full round trip stops the writer inside the legal window, and an illegal offer after that proves the word is dropped and the overflow flag stays set. A long run of back-to-back writes, against a reader throttled by a pseudo-random pattern, forces write events and reads into the same read cycle, which is how a wrong hold rule on the count becomes visible as lost or repeated data.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  typedef enum logic [1:0] {
    OCC_HOLD = 2'd0,
    OCC_INC  = 2'd1,
    OCC_DEC  = 2'd2
  } occ_step_e;

  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/tcf_sync.sv
module tcf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tcf_store.sv
module tcf_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  // A slot is only addressed here once its write has been counted,
  // so the word is settled long before it is looked at.
  assign rdata = cells[raddr];
endmodule

// File: rtl/tcf_wr_port.sv
module tcf_wr_port
  import tcf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          afull_s,
  output logic          wr_ready,
  output logic          wr_overflow,
  output logic          wr_tog,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata
);
  logic [AW-1:0] wptr;
  logic          accept;

  assign wr_ready  = ~afull_s;
  assign accept    = wr_valid & wr_ready;
  assign mem_we    = accept;
  assign mem_waddr = wptr;
  assign mem_wdata = wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr        <= '0;
      wr_tog      <= 1'b0;
      wr_overflow <= 1'b0;
    end else begin
      if (accept) begin
        wptr   <= AW'(wrap_inc(32'(wptr), DEPTH));
        wr_tog <= ~wr_tog;
      end
      if (wr_valid && !wr_ready) wr_overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/tcf_rd_port.sv
module tcf_rd_port
  import tcf_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int AW       = 4,
  parameter int CW       = 5,
  parameter int AF_LEVEL = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tog_s,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic          rd_half,
  output logic          afull_q,
  output logic          wr_evt,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] occ
);
  localparam int HALF = DEPTH / 2;

  logic          tog_seen;
  logic          pop;
  occ_step_e     step;
  logic [CW-1:0] occ_nxt;

  assign wr_evt   = tog_s ^ tog_seen;
  assign rd_valid = (occ != '0);
  assign rd_half  = (occ >= CW'(HALF));
  assign pop      = rd_valid & rd_ready;
  assign raddr    = rptr_q;

  logic [AW-1:0] rptr_q;

  always_comb begin
    unique case ({wr_evt, pop})
      2'b10:   step = OCC_INC;
      2'b01:   step = OCC_DEC;
      default: step = OCC_HOLD;
    endcase
    unique case (step)
      OCC_INC: occ_nxt = occ + 1'b1;
      OCC_DEC: occ_nxt = occ - 1'b1;
      default: occ_nxt = occ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_seen <= 1'b0;
      occ      <= '0;
      rptr_q   <= '0;
      afull_q  <= 1'b0;
    end else begin
      tog_seen <= tog_s;
      occ      <= occ_nxt;
      afull_q  <= (occ_nxt >= CW'(AF_LEVEL));
      if (pop) rptr_q <= AW'(wrap_inc(32'(rptr_q), DEPTH));
    end
  end
endmodule

// File: rtl/tcf_fifo.sv
module tcf_fifo #(
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter int MARGIN = 4
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          wr_afull,
  output logic          wr_overflow,
  input  logic          rd_clk,
  input  logic          rd_rst,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_half
);
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW       = $clog2(DEPTH + 1);
  localparam int AF_LEVEL = DEPTH - MARGIN;
  localparam int SYNC_N   = 2;

  logic          wr_tog, tog_s;
  logic          afull_q, afull_s;
  logic          wr_evt;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata;
  logic [CW-1:0] occ;

  assign wr_afull = afull_s;

  tcf_wr_port #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) wr_port_i (
    .clk(wr_clk), .rst(wr_rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .afull_s(afull_s), .wr_ready(wr_ready), .wr_overflow(wr_overflow),
    .wr_tog(wr_tog), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata)
  );

  tcf_sync #(.STAGES(SYNC_N)) tog_sync_i (
    .clk(rd_clk), .rst(rd_rst), .d(wr_tog), .q(tog_s)
  );

  tcf_sync #(.STAGES(SYNC_N)) afull_sync_i (
    .clk(wr_clk), .rst(wr_rst), .d(afull_q), .q(afull_s)
  );

  tcf_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) store_i (
    .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(rd_data)
  );

  tcf_rd_port #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .AF_LEVEL(AF_LEVEL)) rd_port_i (
    .clk(rd_clk), .rst(rd_rst), .tog_s(tog_s), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_half(rd_half), .afull_q(afull_q),
    .wr_evt(wr_evt), .raddr(mem_raddr), .occ(occ)
  );
endmodule

// File: rtl/tcf_fifo_chk.sv
module tcf_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          wr_clk,
  input logic          wr_rst,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          wr_overflow,
  input logic          wr_tog,
  input logic          rd_clk,
  input logic          rd_rst,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          wr_evt,
  input logic [CW-1:0] occ
);
  logic pop;
  assign pop = rd_valid & rd_ready;

  p_inc_on_event_r3: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (wr_evt && !pop) |=> (occ == $past(occ) + 1'b1));

  p_idle_read_r4: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (!rd_valid && !wr_evt) |=> (occ == '0));

  p_hold_on_both_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (wr_evt && pop) |=> $stable(occ));

  p_occ_bound_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    occ <= CW'(DEPTH));

  p_refuse_when_full_r7: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !wr_ready |=> $stable(wr_tog));

  p_no_overflow_r8: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_valid && !wr_ready) |=> wr_overflow);

  p_overflow_sticky_r8: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_overflow |=> wr_overflow);
endmodule

bind tcf_fifo tcf_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_overflow(wr_overflow), .wr_tog(wr_tog), .rd_clk(rd_clk), .rd_rst(rd_rst),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .wr_evt(wr_evt), .occ(occ)
);

// File: tb/tcf_fifo_tb_top.sv
`timescale 1ns/1ps
module tcf_fifo_tb_top;
  localparam int DW = 8, DEPTH = 16, MARGIN = 4;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst = 1'b1, rd_rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready, wr_afull, wr_overflow;
  logic          rd_valid, rd_half;
  logic          rd_ready = 1'b0;
  logic [DW-1:0] rd_data;

  int   n_chk = 0, n_fail = 0;
  logic [DW-1:0] sb[$];
  bit   rd_en = 1'b0, throttle = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  bit   done = 1'b0;

  always #5  rd_clk = ~rd_clk;   // 100 MHz read clock
  always #15 wr_clk = ~wr_clk;   // slower write clock

  tcf_fifo #(.DW(DW), .DEPTH(DEPTH), .MARGIN(MARGIN)) dut_i (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_afull(wr_afull), .wr_overflow(wr_overflow),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_half(rd_half)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Monitor: drives rd_ready and compares each transfer against the queue (R2).
  always @(negedge rd_clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rd_ready = rd_en && (!throttle || lfsr[0]);
    if (rd_valid && rd_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R4 read with nothing expected", int'(rd_data), -1);
      end else begin
        logic [DW-1:0] exp;
        exp = sb.pop_front();
        check(rd_data === exp, "R2 data order", int'(rd_data), int'(exp));
      end
    end
  end

  task automatic rd_wait(int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic try_push(logic [DW-1:0] d, output bit took);
    @(negedge wr_clk);
    took = 1'b0;
    if (wr_ready) begin
      wr_valid = 1'b1;
      wr_data  = d;
      sb.push_back(d);
      took = 1'b1;
    end
    @(posedge wr_clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic push(logic [DW-1:0] d);
    bit took;
    took = 1'b0;
    while (!took) try_push(d, took);
  endtask

  task automatic drain(string req);
    rd_en = 1'b1;
    for (int i = 0; i < 400 && sb.size() != 0; i++) rd_wait(1);
    rd_wait(6);
    check(sb.size() == 0, req, sb.size(), 0);
    check(rd_valid == 1'b0, req, int'(rd_valid), 0);
  endtask

  task automatic do_reset();
    rd_en = 1'b0;
    wr_rst = 1'b1; rd_rst = 1'b1;
    repeat (4) @(negedge wr_clk);
    wr_rst = 1'b0; rd_rst = 1'b0;
    repeat (2) @(negedge wr_clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      report();
    end
  end

  initial begin
    bit took;
    int acc;

    // R1: reset state
    do_reset();
    check(rd_valid == 0,    "R1 rd_valid",    int'(rd_valid), 0);
    check(rd_half == 0,     "R1 rd_half",     int'(rd_half), 0);
    check(wr_afull == 0,    "R1 wr_afull",    int'(wr_afull), 0);
    check(wr_ready == 1,    "R1 wr_ready",    int'(wr_ready), 1);
    check(wr_overflow == 0, "R1 wr_overflow", int'(wr_overflow), 0);

    // R3: one write is counted once and shows up quickly
    push(8'h3C);
    rd_wait(8);
    check(rd_valid == 1, "R3 single write seen", int'(rd_valid), 1);
    check(rd_half == 0,  "R6 one word not half", int'(rd_half), 0);
    drain("R3 single write drained once");

    // R4: reading an empty FIFO has no effect
    rd_en = 1'b1;
    rd_wait(20);
    check(rd_valid == 0, "R4 empty stays empty", int'(rd_valid), 0);
    push(8'h5A);
    push(8'hC3);
    drain("R4 position unchanged by idle reads");

    // R6: half-full threshold
    rd_en = 1'b0;
    for (int i = 0; i < DEPTH/2 - 1; i++) push(DW'(8'h10 + i));
    rd_wait(12);
    check(rd_half == 0, "R6 below half", int'(rd_half), 0);
    push(8'h77);
    rd_wait(12);
    check(rd_half == 1, "R6 at half", int'(rd_half), 1);
    check(wr_afull == 0, "R7 not yet almost-full", int'(wr_afull), 0);

    // R7: writer stopped inside the legal window
    acc = DEPTH / 2;
    for (int i = 0; i < 30; i++) begin
      try_push(DW'(8'h40 + i), took);
      if (took) acc++;
    end
    check(wr_afull == 1, "R7 almost-full raised", int'(wr_afull), 1);
    check(wr_ready == 0, "R7 ready dropped", int'(wr_ready), 0);
    check(acc >= DEPTH - MARGIN && acc <= DEPTH, "R7 accepted count in window", acc, DEPTH - MARGIN);

    // R8: illegal offer is dropped and flagged
    @(negedge wr_clk);
    wr_valid = 1'b1; wr_data = 8'hEE;
    @(posedge wr_clk);
    #1 wr_valid = 1'b0;
    @(negedge wr_clk);
    check(wr_overflow == 1, "R8 overflow set", int'(wr_overflow), 1);
    drain("R8 dropped word absent");
    repeat (6) @(negedge wr_clk);
    check(wr_afull == 0, "R7 almost-full cleared", int'(wr_afull), 0);
    check(wr_overflow == 1, "R8 overflow sticky", int'(wr_overflow), 1);

    // R5: streaming with a throttled reader
    throttle = 1'b1;
    rd_en = 1'b1;
    for (int i = 0; i < 80; i++) push(DW'(i * 7 + 1));
    drain("R5 concurrent stream intact");
    throttle = 1'b0;
    check(wr_overflow == 1, "R8 still sticky after stream", int'(wr_overflow), 1);

    // R1/R8: reset clears everything
    do_reset();
    check(wr_overflow == 0, "R8 cleared by reset", int'(wr_overflow), 0);
    check(rd_valid == 0,    "R1 rd_valid after second reset", int'(rd_valid), 0);
    check(wr_ready == 1,    "R1 wr_ready after second reset", int'(wr_ready), 1);
    push(8'h99);
    drain("R2 after second reset");

    done = 1'b1;
    report();
  end
endmodule